// File: doc/BRIEF.md
# Host Mailbox Word Interface

This block passes single 16-bit words between an external host and an on-chip processor. The host side is an asynchronous strobe port with an active-low chip select, an address qualifier, an active-low write strobe and an active-low read strobe. The data bus is split into input, output and output-enable signals, so the pad cell outside the block forms the bidirectional pin. The processor side is a simple memory-mapped register port.

Each direction has a single word of storage and a "full" flag. The side that fills a word sets its flag, and the other side clears it. The inbound flag is cleared by an explicit pulse from the processor. The outbound flag is cleared when the host finishes reading the word.

The host strobes, chip select and address qualifier are resynchronized into the processor clock domain. All flag changes take place on edges detected after that resynchronization. The host port does nothing until software writes the enable pattern into the control register.

Top module: `mbx_host_if`

## Requirements
- R1: The host port is enabled only while bits 1 and 2 of the control register (internal address 0xC006, readable and writable) are both 1. While the port is disabled, host writes do not change the inbound word or any flag, host reads leave the outbound flag unchanged, and `hostDataOe` stays 0.
- R2: On a qualified host write, the value on `hostDataIn` is stored as the inbound word. A write is qualified when the resynchronized `hostWrN` rises while `hostCsN` is low and `hostAddr` is high. The inbound word is returned by internal reads of 0xC0C4.
- R3: A qualified host write sets the inbound-full flag. This flag is status bit 1, and status is read at internal address 0xC0C2.
- R4: The inbound-full flag stays set until a one-cycle `clrInFull` pulse clears it. Nothing else clears it except reset.
- R5: An internal write to 0xC0C4 loads the outbound word and sets the outbound-full flag, which is status bit 0.
- R6: `hostDataOe` is 1 and `hostDataOut` carries the outbound word exactly while the port is enabled, `hostRdN` is low, `hostAddr` is high and `hostCsN` is low. This is combinational from the pins. Otherwise `hostDataOe` is 0.
- R7: The resynchronized rising edge of `hostRdN` on a qualified read clears the outbound-full flag.
- R8: A qualified host write that arrives while inbound-full is set, with no clear in the same cycle, overwrites the inbound word and sets the sticky overrun bit, status bit 2. Only reset clears the overrun bit.
- R9: When events fall in the same cycle, a host write completion beats a `clrInFull` pulse, so inbound-full ends up set. An internal load of the outbound word beats a host read completion, so outbound-full ends up set.
- R10: A synchronous active-high `rst` clears the inbound word, the outbound word, the control register, both flags and the overrun bit, and releases the host bus.
- R11: A host write strobe with `hostAddr` low or `hostCsN` high is ignored.
- R12: Status bits 15 to 3 always read as 0. Internal reads of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| hostCsN | input | 1 | Host chip select, active low, asynchronous |
| hostAddr | input | 1 | Host address qualifier, high selects the data word |
| hostWrN | input | 1 | Host write strobe, active low, data taken at its rising edge |
| hostRdN | input | 1 | Host read strobe, active low |
| hostDataIn | input | 16 | Data from the host pad |
| hostDataOut | output | 16 | Data toward the host pad |
| hostDataOe | output | 1 | Host pad output enable |
| busAddr | input | 16 | Internal register address |
| busWrEn | input | 1 | Internal write strobe, one cycle per write |
| busWrData | input | 16 | Internal write data |
| busRdData | output | 16 | Internal read data for `busAddr`, combinational |
| clrInFull | input | 1 | Processor pulse that clears inbound-full |

## Verification
Two pairs of actions can fall in the same clock cycle. The first pair is a host write completion and a processor clear of inbound-full. The second pair is a host read completion and a processor load of the outbound word. The bench provokes each pair by counting the resynchronizer latency from the strobe's rising edge and placing the internal pulse in the exact cycle in which the detected edge takes effect. It then checks, both in its cycle model and with a directed status read, that the setting side won. The overrun rule is tested by a second write made without a clear, followed by a clear that must leave the overrun bit set.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int STAT_OF_BIT  = 0;
  localparam int STAT_IF_BIT  = 1;
  localparam int STAT_OVR_BIT = 2;

  // pin bundle order inside the synchronizer: {csN, addr, wrN, rdN}
  localparam int PIN_CS = 3;
  localparam int PIN_AD = 2;
  localparam int PIN_WR = 1;
  localparam int PIN_RD = 0;
  localparam logic [3:0] PIN_IDLE = 4'b1011;

  typedef struct packed {
    logic captureIn;  // take host word into inbound register
    logic loadOut;    // take internal word into outbound register
    logic driveOut;   // host pad output enable
  } mbxStrobe_t;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int         W       = 4,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hC006,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hC0C4,
  parameter logic [DATA_W-1:0] EN_MASK   = 16'h0006
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        pinSync,
  input  logic              csNRaw,
  input  logic              addrRaw,
  input  logic              rdNRaw,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              clrInFull,
  output mbxStrobe_t        strobe,
  output logic              inFull,
  output logic              outFull,
  output logic              overrun,
  output logic [DATA_W-1:0] ctrlReg
);

  logic wrPrev, rdPrev;
  logic enabled, hostSel, wrRise, rdRise;
  logic hostWrDone, hostRdDone, ctrlWrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPrev <= PIN_IDLE[PIN_WR];
      rdPrev <= PIN_IDLE[PIN_RD];
    end else begin
      wrPrev <= pinSync[PIN_WR];
      rdPrev <= pinSync[PIN_RD];
    end
  end

  assign enabled    = (ctrlReg & EN_MASK) == EN_MASK;
  assign hostSel    = !pinSync[PIN_CS] && pinSync[PIN_AD];
  assign wrRise     = pinSync[PIN_WR] && !wrPrev;
  assign rdRise     = pinSync[PIN_RD] && !rdPrev;
  assign hostWrDone = enabled && hostSel && wrRise;
  assign hostRdDone = enabled && hostSel && rdRise;
  assign ctrlWrite  = busWrEn && (busAddr == CTRL_ADDR);

  always_comb begin
    strobe.captureIn = hostWrDone;
    strobe.loadOut   = busWrEn && (busAddr == DATA_ADDR);
    strobe.driveOut  = enabled && !csNRaw && addrRaw && !rdNRaw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
      inFull  <= 1'b0;
      outFull <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (ctrlWrite) ctrlReg <= busWrData;
      if (hostWrDone) begin
        inFull <= 1'b1;
        if (inFull && !clrInFull) overrun <= 1'b1;
      end else if (clrInFull) begin
        inFull <= 1'b0;
      end
      if (strobe.loadOut)  outFull <= 1'b1;
      else if (hostRdDone) outFull <= 1'b0;
    end
  end

  assert_if_set_R3: assert property (@(posedge clk) disable iff (rst)
    hostWrDone |=> inFull);
  assert_if_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!hostWrDone && !clrInFull) |=> $stable(inFull));
  assert_of_set_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.loadOut |=> outFull);
  assert_of_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (hostRdDone && !strobe.loadOut) |=> !outFull);
  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (!enabled && !clrInFull) |=> $stable(inFull));

endmodule

// File: rtl/mbx_dp.sv
module mbx_dp
  import mbx_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hC006,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hC0C2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hC0C4
) (
  input  logic              clk,
  input  logic              rst,
  input  mbxStrobe_t        strobe,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              inFull,
  input  logic              outFull,
  input  logic              overrun,
  input  logic [DATA_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic [DATA_W-1:0] busRdData
);

  localparam int PAD_W = DATA_W - 3;

  logic [DATA_W-1:0] inWord, outWord, statusWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      inWord  <= '0;
      outWord <= '0;
    end else begin
      if (strobe.captureIn) inWord  <= hostDataIn;
      if (strobe.loadOut)   outWord <= busWrData;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[STAT_OF_BIT]  = outFull;
    statusWord[STAT_IF_BIT]  = inFull;
    statusWord[STAT_OVR_BIT] = overrun;
  end

  always_comb begin
    if (busAddr == DATA_ADDR)      busRdData = inWord;
    else if (busAddr == STAT_ADDR) busRdData = statusWord;
    else if (busAddr == CTRL_ADDR) busRdData = ctrlReg;
    else                           busRdData = '0;
  end

  assign hostDataOe  = strobe.driveOut;
  assign hostDataOut = strobe.driveOut ? outWord : '0;

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.captureIn |=> inWord == $past(hostDataIn));
  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.loadOut |=> outWord == $past(busWrData));
  assert_status_pad_R12: assert property (@(posedge clk) disable iff (rst)
    statusWord[DATA_W-1:3] == PAD_W'(0));

endmodule

// File: rtl/mbx_host_if.sv
module mbx_host_if
  import mbx_pkg::*;
#(
  parameter int              DATA_W      = 16,
  parameter int              ADDR_W      = 16,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'hC006,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 16'hC0C2,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hC0C4,
  parameter logic [DATA_W-1:0] EN_MASK     = 16'h0006
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostCsN,
  input  logic              hostAddr,
  input  logic              hostWrN,
  input  logic              hostRdN,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              clrInFull
);

  logic [3:0]        pinSync;
  mbxStrobe_t        strobe;
  logic              inFull, outFull, overrun;
  logic [DATA_W-1:0] ctrlReg;

  mbx_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) uSync (
    .clk(clk), .rst(rst),
    .asyncIn({hostCsN, hostAddr, hostWrN, hostRdN}),
    .syncOut(pinSync)
  );

  mbx_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
             .DATA_ADDR(DATA_ADDR), .EN_MASK(EN_MASK)) uCtrl (
    .clk(clk), .rst(rst), .pinSync(pinSync),
    .csNRaw(hostCsN), .addrRaw(hostAddr), .rdNRaw(hostRdN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .clrInFull(clrInFull), .strobe(strobe),
    .inFull(inFull), .outFull(outFull), .overrun(overrun), .ctrlReg(ctrlReg)
  );

  mbx_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR),
           .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .hostDataIn(hostDataIn),
    .busAddr(busAddr), .busWrData(busWrData),
    .inFull(inFull), .outFull(outFull), .overrun(overrun), .ctrlReg(ctrlReg),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe), .busRdData(busRdData)
  );

endmodule

// File: tb/sim_mbx_host_if.sv
`timescale 1ns/1ps
module sim_mbx_host_if;

  localparam logic [15:0] A_CTRL = 16'hC006;
  localparam logic [15:0] A_STAT = 16'hC0C2;
  localparam logic [15:0] A_DATA = 16'hC0C4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hostCsN = 1'b1, hostAddr = 1'b0, hostWrN = 1'b1, hostRdN = 1'b1;
  logic [15:0] hostDataIn = '0;
  logic [15:0] hostDataOut;
  logic hostDataOe;
  logic [15:0] busAddr = A_STAT;
  logic busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic clrInFull = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mbx_host_if u0 (
    .clk(clk), .rst(rst), .hostCsN(hostCsN), .hostAddr(hostAddr),
    .hostWrN(hostWrN), .hostRdN(hostRdN), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .clrInFull(clrInFull)
  );

  // behavioural reference model
  logic [15:0] mIn, mOut, mCtrl;
  bit mIF, mOF, mOvr;
  bit [3:0] hist[$];  // {csN, addr, wrN, rdN} sampled at each edge

  always @(posedge clk) begin
    bit [3:0] older, newer;
    bit en, wrDone, rdDone;
    if (rst) begin
      mIn = '0; mOut = '0; mCtrl = '0; mIF = 0; mOF = 0; mOvr = 0;
      hist = '{4'b1011, 4'b1011, 4'b1011};
    end else begin
      older  = hist[0];
      newer  = hist[1];
      en     = (mCtrl & 16'h0006) == 16'h0006;
      wrDone = en && !newer[3] && newer[2] && newer[1] && !older[1];
      rdDone = en && !newer[3] && newer[2] && newer[0] && !older[0];
      if (wrDone) begin
        if (mIF && !clrInFull) mOvr = 1;
        mIn = hostDataIn;
        mIF = 1;
      end else if (clrInFull) mIF = 0;
      if (busWrEn && busAddr == A_DATA) begin
        mOut = busWrData; mOF = 1;
      end else if (rdDone) mOF = 0;
      if (busWrEn && busAddr == A_CTRL) mCtrl = busWrData;
      hist.push_back({hostCsN, hostAddr, hostWrN, hostRdN});
      void'(hist.pop_front());
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    logic [15:0] expRd;
    bit expOe;
    if (!rst && !finished) begin
      #1;
      if (busAddr == A_DATA)      expRd = mIn;
      else if (busAddr == A_STAT) expRd = {13'b0, mOvr, mIF, mOF};
      else if (busAddr == A_CTRL) expRd = mCtrl;
      else                        expRd = '0;
      chk("model busRdData R2 R3 R5 R12", busRdData, expRd);
      expOe = ((mCtrl & 16'h0006) == 16'h0006) && !hostCsN && hostAddr && !hostRdN;
      chk("model hostDataOe R6", {15'b0, hostDataOe}, {15'b0, expOe});
      if (expOe) chk("model hostDataOut R6", hostDataOut, mOut);
    end
  end

  task automatic rdReg(input logic [15:0] a, input string tag, input logic [15:0] exp);
    @(negedge clk); busAddr = a; #1;
    chk(tag, busRdData, exp);
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0; busAddr = A_STAT;
  endtask

  task automatic clrPulse();
    @(negedge clk); clrInFull = 1'b1;
    @(negedge clk); clrInFull = 1'b0;
  endtask

  task automatic hostWrite(input logic [15:0] d, input logic a, input logic cs);
    @(negedge clk); hostCsN = cs; hostAddr = a; hostDataIn = d;
    repeat (2) @(negedge clk); hostWrN = 1'b0;
    repeat (3) @(negedge clk); hostWrN = 1'b1;
    repeat (4) @(negedge clk); hostCsN = 1'b1; hostAddr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hostRead(input logic a, input bit expOe, input logic [15:0] expD,
                          input string tag);
    @(negedge clk); hostCsN = 1'b0; hostAddr = a;
    @(negedge clk); hostRdN = 1'b0;
    repeat (2) @(negedge clk); #1;
    chk(tag, {15'b0, hostDataOe}, {15'b0, expOe});
    if (expOe) chk(tag, hostDataOut, expD);
    @(negedge clk); hostRdN = 1'b1;
    repeat (4) @(negedge clk); hostCsN = 1'b1; hostAddr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R10: reset state
    rdReg(A_STAT, "R10 status after reset", 16'h0000);
    rdReg(A_CTRL, "R10 ctrl after reset", 16'h0000);
    rdReg(A_DATA, "R10 inbound after reset", 16'h0000);
    chk("R10 bus released", {15'b0, hostDataOe}, 16'h0000);

    // R1: disabled port ignores host
    hostWrite(16'h1111, 1'b1, 1'b0);
    rdReg(A_STAT, "R1 write ignored when disabled", 16'h0000);
    rdReg(A_DATA, "R1 inbound untouched when disabled", 16'h0000);
    busWrite(A_DATA, 16'h4321);
    hostRead(1'b1, 1'b0, 16'h0, "R1 no drive when disabled");
    rdReg(A_STAT, "R1 OF kept when disabled", 16'h0001);
    busWrite(A_CTRL, 16'h0004);
    hostWrite(16'h2222, 1'b1, 1'b0);
    rdReg(A_STAT, "R1 half enable ignored", 16'h0001);
    busWrite(A_CTRL, 16'h0006);
    rdReg(A_CTRL, "R1 ctrl readback", 16'h0006);
    hostRead(1'b1, 1'b1, 16'h4321, "R6 drive outbound word");
    rdReg(A_STAT, "R7 OF cleared by host read", 16'h0000);

    // R11: unqualified writes
    hostWrite(16'h3333, 1'b0, 1'b0);
    rdReg(A_STAT, "R11 addr low ignored", 16'h0000);
    hostWrite(16'h4444, 1'b1, 1'b1);
    rdReg(A_STAT, "R11 cs high ignored", 16'h0000);

    // R2 R3 R4
    hostWrite(16'hA5A5, 1'b1, 1'b0);
    rdReg(A_STAT, "R3 IF set", 16'h0002);
    rdReg(A_DATA, "R2 inbound word", 16'hA5A5);
    repeat (10) @(negedge clk);
    rdReg(A_STAT, "R4 IF held", 16'h0002);
    clrPulse();
    rdReg(A_STAT, "R4 IF cleared by pulse", 16'h0000);

    // R8 overrun
    hostWrite(16'h0F0F, 1'b1, 1'b0);
    hostWrite(16'hF00D, 1'b1, 1'b0);
    rdReg(A_STAT, "R8 overrun set", 16'h0006);
    rdReg(A_DATA, "R8 overwrite", 16'hF00D);
    clrPulse();
    rdReg(A_STAT, "R8 overrun sticky", 16'h0004);
    #1 chk("R12 pad bits zero", busRdData & 16'hFFF8, 16'h0000);
    rdReg(16'h1234, "R12 unmapped reads zero", 16'h0000);

    // R10 reset clears everything
    doReset();
    rdReg(A_STAT, "R10 overrun cleared", 16'h0000);
    rdReg(A_DATA, "R10 inbound cleared", 16'h0000);
    busWrite(A_CTRL, 16'h0006);

    // R5 R6 R7
    busWrite(A_DATA, 16'h1234);
    rdReg(A_STAT, "R5 OF set", 16'h0001);
    hostRead(1'b0, 1'b0, 16'h0, "R6 no drive with addr low");
    rdReg(A_STAT, "R7 OF kept on unqualified read", 16'h0001);
    hostRead(1'b1, 1'b1, 16'h1234, "R6 read word");
    rdReg(A_STAT, "R7 OF cleared", 16'h0000);

    // R9: write completion and clear in the same cycle
    @(negedge clk); hostCsN = 1'b0; hostAddr = 1'b1; hostDataIn = 16'h7E57;
    repeat (2) @(negedge clk); hostWrN = 1'b0;
    repeat (3) @(negedge clk); hostWrN = 1'b1;
    repeat (2) @(negedge clk); clrInFull = 1'b1;
    @(negedge clk); clrInFull = 1'b0;
    repeat (2) @(negedge clk); hostCsN = 1'b1; hostAddr = 1'b0;
    rdReg(A_STAT, "R9 write beats clear", 16'h0002);
    rdReg(A_DATA, "R9 word taken", 16'h7E57);
    clrPulse();

    // R9: load and read completion in the same cycle
    busWrite(A_DATA, 16'h5555);
    @(negedge clk); hostCsN = 1'b0; hostAddr = 1'b1;
    @(negedge clk); hostRdN = 1'b0;
    repeat (3) @(negedge clk); hostRdN = 1'b1;
    repeat (2) @(negedge clk); busAddr = A_DATA; busWrData = 16'hBEEF; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0; busAddr = A_STAT;
    repeat (3) @(negedge clk); hostCsN = 1'b1; hostAddr = 1'b0;
    rdReg(A_STAT, "R9 load beats read clear", 16'h0001);
    hostRead(1'b1, 1'b1, 16'hBEEF, "R9 new word readable");
    rdReg(A_STAT, "R7 cleared after second read", 16'h0000);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule